// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block holds the operating state of a DRAM protocol controller. Software or a boot sequencer asks for a change of state with a three-bit request code, and the block answers with an 8-bit status word. Bits 2:0 of that word give the current state. Bits 6:4 give the trigger that caused the last entry into low power. A request is taken only from a state where it is legal. It then passes through a transient request state for a fixed number of cycles before the target state settles. A request that is not legal changes nothing and raises an error pulse.

A built-in walker saves the caller from chaining requests by hand. A single pulse asks it to bring the controller to the config state or to the access state from whatever settled state it is in. The walker waits for any transient state to settle, then issues the needed requests one after another. While it runs it owns the request path, and it signals with a one-cycle pulse when it has finished. When the walk to access starts from low power and the stored trigger equals 1, the walker ends at once and leaves the controller asleep. From any other low-power trigger it wakes the controller, goes through config, and returns to access.

Top module: `dram_opstate_ctrl`

## Requirements
- R1: After a synchronous active-low reset, status is 0 (state init_mem, trigger 0), and req_err, walk_busy and walk_done are 0.
- R2: Status bits 2:0 carry the state code: init_mem=0, config=1, config_req=2, access=3, access_req=4, low_power=5, lp_entry_req=6, lp_exit_req=7. Bits 6:4 carry the trigger, and bits 7 and 3 read 0.
- R3: Request codes are init=0, config=1, go=2, sleep=3 and wakeup=4. The legal moves are:
  - config from init_mem or access leads to config_req;
  - go from config leads to access_req;
  - sleep from access leads to lp_entry_req;
  - wakeup from low_power leads to lp_exit_req;
  - init from config leads to init_mem directly.
  Each move shows on status one cycle after the request.
- R4: Each transient state lasts exactly DWELL cycles and then settles into its target only: config_req to config, access_req to access, lp_entry_req to low_power, lp_exit_req to access.
- R5: A request that is not legal leaves the state and trigger unchanged and drives req_err high in the following cycle. This covers a code the current state does not accept, any request while in a transient state, and codes 5 to 7.
- R6: An accepted sleep request stores lp_trig into status bits 6:4. The value holds while in low power, and an accepted wakeup clears it to 0.
- R7: A walk to config goes as follows:
  - from low_power it issues wakeup and, once access settles, config;
  - from access or init_mem it issues config;
  - in config it ends without issuing any request.
- R8: A walk to access goes as follows:
  - from low_power with trigger 1 it ends with no request;
  - from low_power with any other trigger it issues wakeup, then config, then go;
  - from init_mem it issues config then go;
  - from config it issues go;
  - in access it ends.
- R9: walk_busy is high from the cycle after a walk starts until it ends. walk_done pulses for one cycle as walk_busy falls. An external request made while walk_busy is high is dropped and drives req_err high in the following cycle.
- R10: A walk start pulse seen while walk_busy is high is ignored. When both start pulses arrive together, the walk to config is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | External state-change request strobe |
| req_code | input | 3 | Request code (init=0, config=1, go=2, sleep=3, wakeup=4) |
| lp_trig | input | 3 | Trigger value stored when a sleep request is accepted |
| walk_to_cfg | input | 1 | Start pulse: walk to the config state |
| walk_to_acc | input | 1 | Start pulse: walk to the access state |
| status | output | 8 | {0, trigger[2:0], 0, state[2:0]} |
| req_err | output | 1 | One-cycle pulse for a dropped request |
| walk_busy | output | 1 | Walker owns the request path |
| walk_done | output | 1 | One-cycle pulse when a walk finishes |

## Verification
The bench focuses on a few corner cases.

- **Trigger-1 shortcut.** The walk to access is started from low power with trigger 1 and with other trigger values. A design that ignored the shortcut would wake the controller. A design that skipped the detour would never pass through config.
- **Dwell length.** The bench counts how long config_req is visible. A dwell off by one would stretch or cut every transient state.
- **Rejected requests.** The bench sends requests from the wrong state, during transient states, with codes 5 to 7, and while a walk is running. A design that let any of these through would move the state or stay silent on req_err.
- **Simultaneous starts.** Both walk starts are raised together, and a second start is raised during a walk. Here a wrong priority would end the walk in access instead of config.

// File: rtl/dram_opstate_pkg.sv
package dram_opstate_pkg;

  localparam int TRIG_W = 3;

  typedef enum logic [2:0] {
    ST_INIT_MEM  = 3'd0,
    ST_CONFIG    = 3'd1,
    ST_CFG_REQ   = 3'd2,
    ST_ACCESS    = 3'd3,
    ST_ACC_REQ   = 3'd4,
    ST_LOW_POWER = 3'd5,
    ST_LP_ENTRY  = 3'd6,
    ST_LP_EXIT   = 3'd7
  } opstate_e;

  typedef enum logic [2:0] {
    RQ_INIT   = 3'd0,
    RQ_CONFIG = 3'd1,
    RQ_GO     = 3'd2,
    RQ_SLEEP  = 3'd3,
    RQ_WAKEUP = 3'd4
  } reqcode_e;

  typedef enum logic [1:0] {
    WK_IDLE      = 2'd0,
    WK_TO_CFG    = 2'd1,
    WK_TO_ACC    = 2'd2,
    WK_ACC_CYCLE = 2'd3
  } walk_e;

  typedef struct packed {
    logic     legal;
    opstate_e next;
  } move_t;

  typedef struct packed {
    logic       issue;
    logic [2:0] code;
    logic       finish;
    walk_e      nmode;
  } walk_step_t;

  // Settled states accept requests; the others are transient.
  function automatic logic is_settled(opstate_e s);
    return (s == ST_INIT_MEM) || (s == ST_CONFIG) ||
           (s == ST_ACCESS)   || (s == ST_LOW_POWER);
  endfunction

  // Target of a transient state once its dwell expires.
  function automatic opstate_e settle_target(opstate_e s);
    opstate_e t;
    case (s)
      ST_CFG_REQ:  t = ST_CONFIG;
      ST_ACC_REQ:  t = ST_ACCESS;
      ST_LP_ENTRY: t = ST_LOW_POWER;
      ST_LP_EXIT:  t = ST_ACCESS;
      default:     t = s;
    endcase
    return t;
  endfunction

  // Legality and next state of a request from a settled state.
  function automatic move_t decode_move(opstate_e s, logic [2:0] code);
    move_t m;
    m.legal = 1'b0;
    m.next  = s;
    case (s)
      ST_INIT_MEM: if (code == RQ_CONFIG) begin m.legal = 1'b1; m.next = ST_CFG_REQ; end
      ST_ACCESS: begin
        if (code == RQ_CONFIG) begin m.legal = 1'b1; m.next = ST_CFG_REQ; end
        else if (code == RQ_SLEEP) begin m.legal = 1'b1; m.next = ST_LP_ENTRY; end
      end
      ST_CONFIG: begin
        if (code == RQ_GO) begin m.legal = 1'b1; m.next = ST_ACC_REQ; end
        else if (code == RQ_INIT) begin m.legal = 1'b1; m.next = ST_INIT_MEM; end
      end
      ST_LOW_POWER: if (code == RQ_WAKEUP) begin m.legal = 1'b1; m.next = ST_LP_EXIT; end
      default: m.legal = 1'b0;
    endcase
    return m;
  endfunction

  // One step of the walker, evaluated only in a settled state.
  function automatic walk_step_t walk_plan(walk_e m, opstate_e s, logic [TRIG_W-1:0] trig);
    walk_step_t w;
    w.issue  = 1'b0;
    w.code   = RQ_INIT;
    w.finish = 1'b0;
    w.nmode  = m;
    case (m)
      WK_TO_CFG: begin
        case (s)
          ST_LOW_POWER: begin w.issue = 1'b1; w.code = RQ_WAKEUP; end
          ST_CONFIG:    w.finish = 1'b1;
          default:      begin w.issue = 1'b1; w.code = RQ_CONFIG; end
        endcase
      end
      WK_TO_ACC: begin
        case (s)
          ST_LOW_POWER: begin
            if (trig == TRIG_W'(1)) w.finish = 1'b1;
            else begin w.issue = 1'b1; w.code = RQ_WAKEUP; w.nmode = WK_ACC_CYCLE; end
          end
          ST_ACCESS:   w.finish = 1'b1;
          ST_CONFIG:   begin w.issue = 1'b1; w.code = RQ_GO; end
          default:     begin w.issue = 1'b1; w.code = RQ_CONFIG; end
        endcase
      end
      WK_ACC_CYCLE: begin
        case (s)
          ST_LOW_POWER: begin w.issue = 1'b1; w.code = RQ_WAKEUP; end
          ST_CONFIG:    begin w.issue = 1'b1; w.code = RQ_GO; w.nmode = WK_TO_ACC; end
          default:      begin w.issue = 1'b1; w.code = RQ_CONFIG; w.nmode = WK_TO_ACC; end
        endcase
      end
      default: w.finish = 1'b0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/opstate_fsm.sv
module opstate_fsm
  import dram_opstate_pkg::*;
#(
  parameter int DWELL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_v,
  input  logic [2:0]        req_code,
  input  logic [TRIG_W-1:0] trig_in,
  output opstate_e          state_o,
  output logic [TRIG_W-1:0] trig_o,
  output logic              settled_o,
  output logic              illegal_o
);

  localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

  opstate_e          state_q;
  logic [CW-1:0]     cnt_q;
  logic [TRIG_W-1:0] trig_q;
  logic              illegal_q;

  move_t mv;
  logic  settled;
  logic  accept;
  logic  reject;
  logic  settle_evt;

  always_comb begin
    settled    = is_settled(state_q);
    mv         = decode_move(state_q, req_code);
    accept     = req_v && settled && mv.legal;
    reject     = req_v && !accept;
    settle_evt = !settled && (cnt_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_INIT_MEM;
      cnt_q     <= '0;
      trig_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= reject;
      if (accept) begin
        state_q <= mv.next;
        cnt_q   <= '0;
        if (req_code == RQ_SLEEP)  trig_q <= trig_in;
        if (req_code == RQ_WAKEUP) trig_q <= '0;
      end else if (settle_evt) begin
        state_q <= settle_target(state_q);
        cnt_q   <= '0;
      end else if (!settled) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign state_o   = state_q;
  assign trig_o    = trig_q;
  assign settled_o = settled;
  assign illegal_o = illegal_q;

endmodule

// File: rtl/opstate_walker.sv
module opstate_walker
  import dram_opstate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cfg,
  input  logic              start_acc,
  input  opstate_e          state,
  input  logic [TRIG_W-1:0] trig,
  input  logic              settled,
  output logic              issue_o,
  output logic [2:0]        code_o,
  output logic              busy_o,
  output logic              done_o
);

  walk_e      mode_q;
  logic       done_q;
  walk_step_t step;

  always_comb begin
    step.issue  = 1'b0;
    step.code   = RQ_INIT;
    step.finish = 1'b0;
    step.nmode  = mode_q;
    if (mode_q != WK_IDLE && settled) step = walk_plan(mode_q, state, trig);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= WK_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= step.finish;
      if (step.finish)          mode_q <= WK_IDLE;
      else if (mode_q == WK_IDLE) begin
        if (start_cfg)          mode_q <= WK_TO_CFG;
        else if (start_acc)     mode_q <= WK_TO_ACC;
      end else                  mode_q <= step.nmode;
    end
  end

  assign issue_o = step.issue;
  assign code_o  = step.code;
  assign busy_o  = (mode_q != WK_IDLE);
  assign done_o  = done_q;

endmodule

// File: rtl/dram_opstate_ctrl.sv
module dram_opstate_ctrl
  import dram_opstate_pkg::*;
#(
  parameter int DWELL = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_code,
  input  logic [2:0] lp_trig,
  input  logic       walk_to_cfg,
  input  logic       walk_to_acc,
  output logic [7:0] status,
  output logic       req_err,
  output logic       walk_busy,
  output logic       walk_done
);

  opstate_e          cur_state;
  logic [TRIG_W-1:0] cur_trig;
  logic              settled;
  logic              fsm_illegal;
  logic              w_issue;
  logic [2:0]        w_code;
  logic              w_busy;
  logic              fsm_req_v;
  logic [2:0]        fsm_req_code;
  logic              ext_reject;
  logic              ext_reject_q;

  // The walker owns the request path while it runs.
  assign fsm_req_v    = w_busy ? w_issue : req_valid;
  assign fsm_req_code = w_busy ? w_code  : req_code;
  assign ext_reject   = w_busy && req_valid;

  opstate_fsm #(.DWELL(DWELL)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_v     (fsm_req_v),
    .req_code  (fsm_req_code),
    .trig_in   (lp_trig),
    .state_o   (cur_state),
    .trig_o    (cur_trig),
    .settled_o (settled),
    .illegal_o (fsm_illegal)
  );

  opstate_walker u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_cfg (walk_to_cfg),
    .start_acc (walk_to_acc),
    .state     (cur_state),
    .trig      (cur_trig),
    .settled   (settled),
    .issue_o   (w_issue),
    .code_o    (w_code),
    .busy_o    (w_busy),
    .done_o    (walk_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ext_reject_q <= 1'b0;
    else        ext_reject_q <= ext_reject;
  end

  assign status    = {1'b0, cur_trig, 1'b0, cur_state};
  assign req_err   = fsm_illegal | ext_reject_q;
  assign walk_busy = w_busy;

endmodule

// File: rtl/opstate_chk.sv
module opstate_chk
  import dram_opstate_pkg::*;
#(
  parameter int DWELL = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_code,
  input logic [7:0] status,
  input logic       req_err,
  input logic       walk_busy,
  input logic       walk_done
);

  logic [2:0] st;
  logic [2:0] trg;
  int         run_q;

  assign st  = status[2:0];
  assign trg = status[6:4];

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 0;
    else if (!is_settled(opstate_e'(st))) run_q <= run_q + 1;
    else run_q <= 0;
  end

  // R4
  dwell_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) run_q <= DWELL);

  // R4
  cfg_req_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CFG_REQ) |=> (st == ST_CFG_REQ || st == ST_CONFIG));

  // R4
  lp_exit_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LP_EXIT) |=> (st == ST_LP_EXIT || st == ST_ACCESS));

  // R5
  illegal_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !walk_busy && st == ST_INIT_MEM && req_code == RQ_GO)
      |=> (req_err && st == ST_INIT_MEM));

  // R6
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOW_POWER) |=> (st != ST_LOW_POWER || $stable(trg)));

  // R9
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && walk_busy) |=> req_err);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> !walk_busy);

endmodule

bind dram_opstate_ctrl opstate_chk #(.DWELL(DWELL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_code  (req_code),
  .status    (status),
  .req_err   (req_err),
  .walk_busy (walk_busy),
  .walk_done (walk_done)
);

// File: tb/sim_dram_opstate_ctrl.sv
`timescale 1ns/1ps
module sim_dram_opstate_ctrl;

  localparam int DW = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_code = 3'd0;
  logic [2:0] lp_trig = 3'd0;
  logic       walk_to_cfg = 1'b0;
  logic       walk_to_acc = 1'b0;
  logic [7:0] status;
  logic       req_err;
  logic       walk_busy;
  logic       walk_done;

  always #4 clk = ~clk;

  dram_opstate_ctrl #(.DWELL(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .lp_trig(lp_trig), .walk_to_cfg(walk_to_cfg), .walk_to_acc(walk_to_acc),
    .status(status), .req_err(req_err), .walk_busy(walk_busy), .walk_done(walk_done)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    armed = 0;
  string phase_tag = "R3";

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Reference model: state codes and request codes as stated in R2/R3.
  int m_state = 0, m_cnt = 0, m_trig = 0, m_mode = 0, m_err = 0, m_done = 0;

  function automatic int steady(input int s);
    return (s == 0 || s == 1 || s == 3 || s == 5) ? 1 : 0;
  endfunction

  function automatic int land(input int s);
    case (s)
      2: return 1;
      4: return 3;
      6: return 5;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    int wi, wc, wf, nm, rv, rc, rej, ill, busy_now;
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_trig = 0; m_mode = 0; m_err = 0; m_done = 0;
    end else begin
      wi = 0; wc = 0; wf = 0; nm = m_mode;
      if (m_mode != 0 && steady(m_state) == 1) begin
        if (m_mode == 1) begin
          if (m_state == 1) wf = 1;
          else begin wi = 1; wc = (m_state == 5) ? 4 : 1; end
        end else if (m_mode == 2) begin
          if (m_state == 3) wf = 1;
          else if (m_state == 5) begin
            if (m_trig == 1) wf = 1; else begin wi = 1; wc = 4; nm = 3; end
          end else if (m_state == 1) begin wi = 1; wc = 2; end
          else begin wi = 1; wc = 1; end
        end else begin
          if (m_state == 5) begin wi = 1; wc = 4; end
          else if (m_state == 1) begin wi = 1; wc = 2; nm = 2; end
          else begin wi = 1; wc = 1; nm = 2; end
        end
      end
      busy_now = (m_mode != 0) ? 1 : 0;
      rv  = busy_now ? wi : int'(req_valid);
      rc  = busy_now ? wc : int'(req_code);
      rej = busy_now ? int'(req_valid) : 0;
      ill = 0;
      if (steady(m_state) == 0) begin
        if (rv == 1) ill = 1;
        if (m_cnt == DW - 1) begin m_state = land(m_state); m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end else if (rv == 1) begin
        if ((m_state == 0 || m_state == 3) && rc == 1) begin m_state = 2; m_cnt = 0; end
        else if (m_state == 3 && rc == 3) begin m_state = 6; m_cnt = 0; m_trig = int'(lp_trig); end
        else if (m_state == 1 && rc == 2) begin m_state = 4; m_cnt = 0; end
        else if (m_state == 1 && rc == 0) begin m_state = 0; m_cnt = 0; end
        else if (m_state == 5 && rc == 4) begin m_state = 7; m_cnt = 0; m_trig = 0; end
        else ill = 1;
      end
      m_err  = (ill == 1 || rej == 1) ? 1 : 0;
      m_done = wf;
      if (wf == 1) m_mode = 0;
      else if (m_mode == 0) begin
        if (walk_to_cfg) m_mode = 1;
        else if (walk_to_acc) m_mode = 2;
      end else m_mode = nm;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk(phase_tag, int'(status[2:0]), m_state);
      chk("R6", int'(status[6:4]), m_trig);
      chk("R2", int'({status[7], status[3]}), 0);
      chk("R5", int'(req_err), m_err);
      chk("R9", int'(walk_busy), (m_mode != 0) ? 1 : 0);
      chk("R9", int'(walk_done), m_done);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_req(input int code, input int trig);
    req_valid = 1'b1; req_code = 3'(code); lp_trig = 3'(trig);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic walk(input bit to_cfg, input bit to_acc);
    walk_to_cfg = to_cfg; walk_to_acc = to_acc;
    @(negedge clk);
    walk_to_cfg = 1'b0; walk_to_acc = 1'b0;
  endtask

  task automatic wait_done(output bit seen_cfg, output bit got);
    seen_cfg = 0; got = 0;
    for (int i = 0; i < 80; i++) begin
      if (status[2:0] == 3'd1) seen_cfg = 1;
      if (walk_done) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    bit sc, gd;
    int cnt;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1", int'(status), 0);
    chk("R1", int'(req_err), 0);
    chk("R1", int'(walk_busy), 0);
    chk("R1", int'(walk_done), 0);
    rst_n = 1'b1;
    armed = 1;
    @(negedge clk);

    // Dwell length of config_req
    phase_tag = "R4";
    do_req(1, 0);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      if (status[2:0] == 3'd2) cnt++;
      @(negedge clk);
    end
    chk("R4 config_req dwell", cnt, DW);
    chk("R3 settled config", int'(status[2:0]), 1);

    // Illegal requests
    phase_tag = "R5";
    do_req(3, 2);
    chk("R5 sleep from config err", int'(req_err), 1);
    chk("R5 state kept", int'(status[2:0]), 1);
    do_req(7, 0);
    chk("R5 code 7 err", int'(req_err), 1);

    phase_tag = "R3";
    do_req(2, 0);
    do_req(2, 0);
    chk("R5 req in transient err", int'(req_err), 1);
    idle(5);
    chk("R3 go reaches access", int'(status[2:0]), 3);
    do_req(3, 1);
    idle(5);
    chk("R3 sleep reaches low power", int'(status[2:0]), 5);
    chk("R6 trigger stored", int'(status[6:4]), 1);

    // Walk to access with trigger 1: shortcut
    phase_tag = "R8";
    walk(0, 1);
    wait_done(sc, gd);
    chk("R8 trig1 walk done", int'(gd), 1);
    chk("R8 trig1 stays low power", int'(status[2:0]), 5);

    phase_tag = "R7";
    walk(1, 0);
    wait_done(sc, gd);
    chk("R7 walk to config done", int'(gd), 1);
    chk("R7 ends in config", int'(status[2:0]), 1);

    phase_tag = "R8";
    walk(0, 1);
    wait_done(sc, gd);
    chk("R8 config to access", int'(status[2:0]), 3);
    do_req(3, 2);
    idle(5);
    walk(0, 1);
    wait_done(sc, gd);
    chk("R8 detour through config", int'(sc), 1);
    chk("R8 ends in access", int'(status[2:0]), 3);

    // Both starts together, then a second start and an external request mid-walk
    phase_tag = "R10";
    walk(1, 1);
    wait_done(sc, gd);
    chk("R10 config wins", int'(status[2:0]), 1);
    do_req(2, 0);
    idle(5);
    walk(1, 0);
    walk_to_acc = 1'b1; req_valid = 1'b1; req_code = 3'd3; lp_trig = 3'd6;
    @(negedge clk);
    walk_to_acc = 1'b0; req_valid = 1'b0;
    chk("R9 external during walk err", int'(req_err), 1);
    wait_done(sc, gd);
    chk("R10 late start ignored", int'(status[2:0]), 1);
    idle(3);
    chk("R10 still config", int'(status[2:0]), 1);

    // Wakeup clears trigger
    phase_tag = "R6";
    do_req(2, 0); idle(5);
    do_req(3, 5); idle(5);
    chk("R6 trigger 5", int'(status[6:4]), 5);
    do_req(4, 0); idle(5);
    chk("R6 cleared on wakeup", int'(status[6:4]), 0);
    chk("R3 wakeup to access", int'(status[2:0]), 3);
    do_req(1, 0); idle(5);
    do_req(0, 0);
    chk("R3 init direct", int'(status[2:0]), 0);

    // Random mix
    phase_tag = "R3";
    for (int i = 0; i < 5000; i++) begin
      req_valid   = ($urandom % 3) == 0;
      req_code    = 3'($urandom % 6);
      lp_trig     = 3'($urandom % 8);
      walk_to_cfg = ($urandom % 30) == 0;
      walk_to_acc = ($urandom % 25) == 0;
      @(negedge clk);
    end
    req_valid = 1'b0; walk_to_cfg = 1'b0; walk_to_acc = 1'b0;
    idle(40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule